// File: doc/BRIEF.md
# Special-Register File with Access Checks

This block is the architectural register file of a 32-bit processor core. It keeps sixteen general-purpose registers together with four dedicated registers (accumulator, stack pointer, base pointer and return address) and two privileged registers (interrupt table base and memory map). It also decodes a handful of identifiers that name no storage: a constant-zero source, a read-only view of the program counter and a set of placeholder codes that must never be used.

Two combinational read ports and one clocked write port share a 5-bit identifier space. The write port has three merge modes: full word, low-half immediate (the upper half is cleared) and high-half immediate (the lower half is kept). A kernel-mode input gates every access to the privileged registers. Two fault flags report, in the same cycle, any enabled access that breaks the privilege rule or that names a placeholder code. Raising the flag is the only reaction. The exception path lies outside the block.

Each identifier falls into one of five classes: STORED (general, dedicated), ZERO, PCVIEW, PRIV and NULL. The read multiplexer and the write-permission logic both branch on this class.

Top module: `sprf_core`

## Requirements
- R1: Codes 0 to 15 select general registers and codes 16 to 19 select accumulator, stack pointer, base pointer and return address. A write replaces the register and a read returns it. All storage reads 0 after reset.
- R2: Code 20 is the zero register. Reads of it return 0, writes to it change nothing, and neither raises a fault.
- R3: Code 21 reads the value on `pc_value`. A write to it changes nothing and raises no fault.
- R4: Codes 22 and 23 are privileged. With `kernel_mode` high they read and write like storage. With `kernel_mode` low, an enabled access raises `priv_fault`, a read returns 0 and a write is suppressed.
- R5: Codes 24 to 31 are placeholders. An enabled access to one raises `null_fault`, a read returns 0 and no state changes.
- R6: `wr_mode` 2'b01 writes {16'h0000, wr_data[15:0]} to the target.
- R7: `wr_mode` 2'b10 writes {wr_data[15:0], old[15:0]} to the target, keeping its lower half.
- R8: `wr_mode` 2'b00 writes `wr_data` whole. The code 2'b11 behaves the same.
- R9: A write takes effect at the rising clock edge. A read of the same register in the same cycle returns the old value.
- R10: The fault flags are combinational over the current cycle's enabled accesses. A port whose enable is low raises no fault whatever its identifier.
- R11: The two read ports are independent and may select different or equal identifiers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| kernel_mode | input | 1 | High when the core runs privileged code |
| pc_value | input | 32 | Current program counter, returned for code 21 |
| rd_a_en | input | 1 | Read port A access valid (gates faults) |
| rd_a_id | input | 5 | Read port A identifier |
| rd_a_data | output | 32 | Read port A data |
| rd_b_en | input | 1 | Read port B access valid (gates faults) |
| rd_b_id | input | 5 | Read port B identifier |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write request |
| wr_id | input | 5 | Write identifier |
| wr_mode | input | 2 | 00 full, 01 low immediate, 10 high immediate, 11 full |
| wr_data | input | 32 | Write data; immediates use bits 15:0 |
| priv_fault | output | 1 | Enabled privileged access outside kernel mode this cycle |
| null_fault | output | 1 | Enabled access to a placeholder code this cycle |

## Verification
Directed sequences exercise each identifier class with each write mode. A full word followed by a low immediate separates a correct clear of the upper half from a plain low-half merge. A high immediate following it shows whether the lower half is kept. Privileged codes are tried in both kernel and user mode, which separates suppression from a silent write. Placeholder and zero codes are tried with enables high and low, which separates fault gating from decode. A long pseudo-random run of mixed identifiers, modes and privilege levels is then compared every cycle against a behavioural model, so read-during-write ordering and the independence of the two ports get broad coverage.

// File: rtl/sprf_pkg.sv
package sprf_pkg;

    typedef enum logic [2:0] {
        CLS_STORED = 3'd0,
        CLS_ZERO   = 3'd1,
        CLS_PCVIEW = 3'd2,
        CLS_PRIV   = 3'd3,
        CLS_NULL   = 3'd4
    } id_class_e;

    typedef enum logic [1:0] {
        WM_FULL     = 2'b00,
        WM_LOW      = 2'b01,
        WM_HIGH     = 2'b10,
        WM_FULL_ALT = 2'b11
    } wr_mode_e;

endpackage

// File: rtl/sprf_classify.sv
module sprf_classify
    import sprf_pkg::*;
#(
    parameter int ID_W     = 5,
    parameter int NUM_GEN  = 16,
    parameter int NUM_AUX  = 4,
    parameter int NUM_PRIV = 2,
    parameter int SLOT_W   = 5
) (
    input  logic [ID_W-1:0]   id,
    output id_class_e         cls,
    output logic [SLOT_W-1:0] slot
);
    localparam int ZERO_ID = NUM_GEN + NUM_AUX;
    localparam int PC_ID   = ZERO_ID + 1;
    localparam int PRIV_LO = PC_ID + 1;
    localparam int PRIV_HI = PRIV_LO + NUM_PRIV - 1;

    localparam logic [ID_W-1:0] ZERO_CODE    = ID_W'(ZERO_ID);
    localparam logic [ID_W-1:0] PC_CODE      = ID_W'(PC_ID);
    localparam logic [ID_W-1:0] PRIV_LO_CODE = ID_W'(PRIV_LO);
    localparam logic [ID_W-1:0] PRIV_HI_CODE = ID_W'(PRIV_HI);

    // Privileged registers sit right after the stored general/dedicated slots.
    always_comb begin
        cls  = CLS_NULL;
        slot = '0;
        if (id < ZERO_CODE) begin
            cls  = CLS_STORED;
            slot = SLOT_W'(id);
        end else if (id == ZERO_CODE) begin
            cls = CLS_ZERO;
        end else if (id == PC_CODE) begin
            cls = CLS_PCVIEW;
        end else if (id >= PRIV_LO_CODE && id <= PRIV_HI_CODE) begin
            cls  = CLS_PRIV;
            slot = SLOT_W'(id - PRIV_LO_CODE) + SLOT_W'(ZERO_ID);
        end
    end
endmodule

// File: rtl/sprf_merge.sv
module sprf_merge
    import sprf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  wr_mode_e          mode,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] merged
);
    localparam int HALF = DATA_W / 2;
    localparam int TOP  = DATA_W - HALF;

    always_comb begin
        unique case (mode)
            WM_LOW:  merged = {{TOP{1'b0}}, new_val[HALF-1:0]};
            WM_HIGH: merged = {new_val[TOP-1:0], old_val[HALF-1:0]};
            WM_FULL, WM_FULL_ALT: merged = new_val;
            default: merged = new_val;
        endcase
    end
endmodule

// File: rtl/sprf_core.sv
module sprf_core
    import sprf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ID_W    = 5,
    parameter int NUM_GEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kernel_mode,
    input  logic [DATA_W-1:0] pc_value,
    input  logic              rd_a_en,
    input  logic [ID_W-1:0]   rd_a_id,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic              rd_b_en,
    input  logic [ID_W-1:0]   rd_b_id,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [1:0]        wr_mode,
    input  logic [DATA_W-1:0] wr_data,
    output logic              priv_fault,
    output logic              null_fault
);
    localparam int NUM_AUX  = 4;
    localparam int NUM_PRIV = 2;
    localparam int NUM_SLOT = NUM_GEN + NUM_AUX + NUM_PRIV;
    localparam int SLOT_W   = $clog2(NUM_SLOT);
    localparam int NUM_RD   = 2;
    localparam int HALF     = DATA_W / 2;
    localparam logic [ID_W-1:0] ZERO_CODE = ID_W'(NUM_GEN + NUM_AUX);
    localparam logic [ID_W-1:0] PC_CODE   = ID_W'(NUM_GEN + NUM_AUX + 1);
    localparam logic [ID_W-1:0] PRIV_LO   = ID_W'(NUM_GEN + NUM_AUX + 2);
    localparam logic [ID_W-1:0] PRIV_HI   = ID_W'(NUM_GEN + NUM_AUX + 1 + NUM_PRIV);

    logic [DATA_W-1:0] store_q [NUM_SLOT];

    // ---------------- read ports ----------------
    logic [NUM_RD-1:0]             rd_en_v;
    logic [NUM_RD-1:0][ID_W-1:0]   rd_id_v;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_val_v;
    logic [NUM_RD-1:0]             rd_pfault_v;
    logic [NUM_RD-1:0]             rd_nfault_v;

    assign rd_en_v   = {rd_b_en, rd_a_en};
    assign rd_id_v   = {rd_b_id, rd_a_id};
    assign rd_a_data = rd_val_v[0];
    assign rd_b_data = rd_val_v[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        id_class_e         cls;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] val;

        sprf_classify #(
            .ID_W(ID_W), .NUM_GEN(NUM_GEN), .NUM_AUX(NUM_AUX),
            .NUM_PRIV(NUM_PRIV), .SLOT_W(SLOT_W)
        ) u_cls (
            .id(rd_id_v[p]), .cls(cls), .slot(slot)
        );

        always_comb begin
            unique case (cls)
                CLS_STORED: val = store_q[slot];
                CLS_ZERO:   val = '0;
                CLS_PCVIEW: val = pc_value;
                CLS_PRIV:   val = kernel_mode ? store_q[slot] : '0;
                CLS_NULL:   val = '0;
                default:    val = '0;
            endcase
        end

        assign rd_val_v[p]    = val;
        assign rd_pfault_v[p] = rd_en_v[p] && (cls == CLS_PRIV) && !kernel_mode;
        assign rd_nfault_v[p] = rd_en_v[p] && (cls == CLS_NULL);
    end

    // ---------------- write port ----------------
    id_class_e         wr_cls;
    logic [SLOT_W-1:0] wr_slot;
    logic [DATA_W-1:0] wr_old;
    logic [DATA_W-1:0] wr_merged;
    logic              wr_allowed;
    logic [NUM_SLOT-1:0] slot_we;

    sprf_classify #(
        .ID_W(ID_W), .NUM_GEN(NUM_GEN), .NUM_AUX(NUM_AUX),
        .NUM_PRIV(NUM_PRIV), .SLOT_W(SLOT_W)
    ) u_wr_cls (
        .id(wr_id), .cls(wr_cls), .slot(wr_slot)
    );

    assign wr_old = store_q[wr_slot];

    sprf_merge #(.DATA_W(DATA_W)) u_merge (
        .mode(wr_mode_e'(wr_mode)), .old_val(wr_old),
        .new_val(wr_data), .merged(wr_merged)
    );

    always_comb begin
        unique case (wr_cls)
            CLS_STORED: wr_allowed = wr_en;
            CLS_PRIV:   wr_allowed = wr_en && kernel_mode;
            CLS_ZERO, CLS_PCVIEW, CLS_NULL: wr_allowed = 1'b0;
            default:    wr_allowed = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
        assign slot_we[i] = wr_allowed && (wr_slot == SLOT_W'(i));

        // R6: low immediate leaves the upper half clear
        a_r6_low_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
            slot_we[i] && (wr_mode == 2'b01) |=> store_q[i][DATA_W-1:HALF] == '0);
        // R7: high immediate keeps the lower half
        a_r7_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
            slot_we[i] && (wr_mode == 2'b10)
            |=> store_q[i][HALF-1:0] == $past(store_q[i][HALF-1:0]));
        // R9: a slot changes only at an edge where it was written
        a_r9_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_we[i] |=> $stable(store_q[i]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOT; i++) store_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_SLOT; i++)
                if (slot_we[i]) store_q[i] <= wr_merged;
        end
    end

    // ---------------- fault flags ----------------
    assign priv_fault = (|rd_pfault_v) || (wr_en && (wr_cls == CLS_PRIV) && !kernel_mode);
    assign null_fault = (|rd_nfault_v) || (wr_en && (wr_cls == CLS_NULL));

    // R2: zero code reads as zero on port A
    a_r2_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_id == ZERO_CODE |-> rd_a_data == '0);
    // R3: pc view follows the pc input
    a_r3_pc_view: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_id == PC_CODE |-> rd_b_data == pc_value);
    // R4: user-mode privileged write is flagged
    a_r4_user_priv_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !kernel_mode && wr_id >= PRIV_LO && wr_id <= PRIV_HI |-> priv_fault);
    // R5: placeholder access on port A is flagged and reads zero
    a_r5_null_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_en && rd_a_id > PRIV_HI |-> null_fault && rd_a_data == '0);
    // R10: no enabled access, no fault
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_a_en && !rd_b_en && !wr_en |-> !priv_fault && !null_fault);
endmodule

// File: tb/sprf_core_bench.sv
module sprf_core_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        kernel_mode;
    logic [31:0] pc_value;
    logic        rd_a_en, rd_b_en, wr_en;
    logic [4:0]  rd_a_id, rd_b_id, wr_id;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic [1:0]  wr_mode;
    logic        priv_fault, null_fault;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [32];

    always #5 clk = ~clk;

    sprf_core u_sprf_core (
        .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode), .pc_value(pc_value),
        .rd_a_en(rd_a_en), .rd_a_id(rd_a_id), .rd_a_data(rd_a_data),
        .rd_b_en(rd_b_en), .rd_b_id(rd_b_id), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_id(wr_id), .wr_mode(wr_mode), .wr_data(wr_data),
        .priv_fault(priv_fault), .null_fault(null_fault)
    );

    function automatic string tag_of(input logic [4:0] id);
        if (id < 5'd20) return "R1";
        if (id == 5'd20) return "R2";
        if (id == 5'd21) return "R3";
        if (id <= 5'd23) return "R4";
        return "R5";
    endfunction

    function automatic logic [31:0] m_read(input logic [4:0] id);
        if (id < 5'd20) return mdl[id];
        if (id == 5'd20) return 32'h0;
        if (id == 5'd21) return pc_value;
        if (id <= 5'd23) return kernel_mode ? mdl[id] : 32'h0;
        return 32'h0;
    endfunction

    function automatic logic m_pfault();
        logic f = 1'b0;
        if (!kernel_mode) begin
            if (rd_a_en && (rd_a_id == 5'd22 || rd_a_id == 5'd23)) f = 1'b1;
            if (rd_b_en && (rd_b_id == 5'd22 || rd_b_id == 5'd23)) f = 1'b1;
            if (wr_en && (wr_id == 5'd22 || wr_id == 5'd23)) f = 1'b1;
        end
        return f;
    endfunction

    function automatic logic m_nfault();
        return (rd_a_en && rd_a_id >= 5'd24) || (rd_b_en && rd_b_id >= 5'd24)
            || (wr_en && wr_id >= 5'd24);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic k, input logic [31:0] pc,
                         input logic ae, input logic [4:0] aid,
                         input logic be, input logic [4:0] bid,
                         input logic we, input logic [4:0] wid,
                         input logic [1:0] wm, input logic [31:0] wd);
        kernel_mode = k; pc_value = pc;
        rd_a_en = ae; rd_a_id = aid; rd_b_en = be; rd_b_id = bid;
        wr_en = we; wr_id = wid; wr_mode = wm; wr_data = wd;
    endtask

    // compare all outputs against the model
    task automatic settle();
        #2;
        chk(tag_of(rd_a_id), rd_a_data, m_read(rd_a_id));
        chk(tag_of(rd_b_id), rd_b_data, m_read(rd_b_id));
        chk("R4 priv_fault", {31'b0, priv_fault}, {31'b0, m_pfault()});
        chk("R5 null_fault", {31'b0, null_fault}, {31'b0, m_nfault()});
    endtask

    // clock edge: model commits the write
    task automatic advance();
        logic ok;
        @(posedge clk);
        ok = wr_en && ((wr_id < 5'd20) ||
             ((wr_id == 5'd22 || wr_id == 5'd23) && kernel_mode));
        if (ok) begin
            case (wr_mode)
                2'b01:   mdl[wr_id] = {16'h0000, wr_data[15:0]};
                2'b10:   mdl[wr_id] = {wr_data[15:0], mdl[wr_id][15:0]};
                default: mdl[wr_id] = wr_data;
            endcase
        end
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
        rst_n = 1'b0;
        drive(1, 32'h1000, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every code
        for (int i = 0; i < 32; i++) begin
            drive(1, 32'h1000, 0, 5'(i), 0, 5'(i), 0, 0, 0, 0);
            #2;
            chk("R1 reset", rd_a_data, (i == 21) ? 32'h1000 : 32'h0);
            @(negedge clk);
        end

        // R8: full word, mode 00 and 11
        drive(1, 32'h1000, 1, 3, 1, 17, 1, 3, 2'b00, 32'hDEADBEEF); settle(); advance();
        drive(1, 32'h1000, 1, 3, 1, 17, 1, 17, 2'b11, 32'h12345678); settle();
        chk("R8 full word", rd_a_data, 32'hDEADBEEF); advance();
        drive(1, 32'h1000, 1, 17, 0, 0, 0, 0, 0, 0); settle();
        chk("R8 alt full word", rd_a_data, 32'h12345678); advance();

        // R6 then R7 on the accumulator
        drive(1, 32'h1000, 1, 16, 0, 0, 1, 16, 2'b00, 32'hFFFFFFFF); settle(); advance();
        drive(1, 32'h1000, 1, 16, 0, 0, 1, 16, 2'b01, 32'hAAAA5555); settle(); advance();
        drive(1, 32'h1000, 1, 16, 0, 0, 1, 16, 2'b10, 32'h0000ABCD); settle();
        chk("R6 low imm clears top", rd_a_data, 32'h00005555); advance();
        drive(1, 32'h1000, 1, 16, 0, 0, 0, 0, 0, 0); settle();
        chk("R7 high imm keeps low", rd_a_data, 32'hABCD5555); advance();

        // R2: zero register ignores writes, no fault
        drive(1, 32'h1000, 1, 20, 0, 0, 1, 20, 2'b00, 32'h1); settle();
        chk("R2 no fault", {30'b0, priv_fault, null_fault}, 32'h0); advance();
        drive(1, 32'h1000, 1, 20, 0, 0, 0, 0, 0, 0); settle();
        chk("R2 reads zero", rd_a_data, 32'h0); advance();

        // R3: pc view
        drive(1, 32'h1000, 1, 21, 0, 0, 1, 21, 2'b00, 32'h5); settle();
        chk("R3 pc write no fault", {30'b0, priv_fault, null_fault}, 32'h0); advance();
        drive(0, 32'h2222, 0, 0, 1, 21, 0, 0, 0, 0); settle();
        chk("R3 pc follows input", rd_b_data, 32'h2222); advance();

        // R4: privileged registers
        drive(1, 32'h0, 1, 22, 0, 0, 1, 22, 2'b00, 32'h77); settle(); advance();
        drive(1, 32'h0, 1, 22, 0, 0, 0, 0, 0, 0); settle();
        chk("R4 kernel read", rd_a_data, 32'h77); advance();
        drive(0, 32'h0, 1, 22, 0, 0, 0, 0, 0, 0); settle();
        chk("R4 user read zero", rd_a_data, 32'h0);
        chk("R4 user read fault", {31'b0, priv_fault}, 32'h1); advance();
        drive(0, 32'h0, 0, 0, 0, 0, 1, 23, 2'b00, 32'h99); settle();
        chk("R4 user write fault", {31'b0, priv_fault}, 32'h1); advance();
        drive(1, 32'h0, 1, 23, 0, 0, 0, 0, 0, 0); settle();
        chk("R4 user write suppressed", rd_a_data, 32'h0); advance();

        // R5: placeholders on every port
        drive(1, 32'h0, 1, 31, 0, 0, 0, 0, 0, 0); settle();
        chk("R5 read fault", {31'b0, null_fault}, 32'h1); advance();
        drive(1, 32'h0, 0, 0, 1, 24, 0, 0, 0, 0); settle();
        chk("R5 port B fault", {31'b0, null_fault}, 32'h1); advance();
        drive(1, 32'h0, 0, 0, 0, 0, 1, 26, 2'b00, 32'hFFFF); settle();
        chk("R5 write fault", {31'b0, null_fault}, 32'h1); advance();

        // R9: read during write sees old value
        drive(1, 32'h0, 1, 5, 0, 0, 1, 5, 2'b00, 32'h55); settle();
        chk("R9 old value same cycle", rd_a_data, 32'h0); advance();
        drive(1, 32'h0, 1, 5, 0, 0, 0, 0, 0, 0); settle();
        chk("R9 new value next cycle", rd_a_data, 32'h55); advance();

        // R10: disabled ports raise nothing
        drive(0, 32'h0, 0, 31, 0, 22, 0, 23, 2'b00, 32'h1); settle();
        chk("R10 idle no fault", {30'b0, priv_fault, null_fault}, 32'h0); advance();

        // R11: independent ports
        drive(1, 32'h0, 1, 3, 1, 16, 0, 0, 0, 0); settle();
        chk("R11 port A", rd_a_data, 32'hDEADBEEF);
        chk("R11 port B", rd_b_data, 32'hABCD5555); advance();

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            drive(($urandom % 4) != 0, $urandom,
                  1'($urandom), 5'($urandom), 1'($urandom), 5'($urandom),
                  ($urandom % 3) != 0, 5'($urandom), 2'($urandom), $urandom);
            settle();
            advance();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule